// File: doc/BRIEF.md
# Pipelined AXI4-Lite Register Access Bridge

This block sits between an AXI4-Lite slave port and a register file that takes one request per cycle and answers each one a fixed number of cycles later, in order, with no backpressure. It captures address and data beats in one-entry holding stages, combines a write address with its write data, picks between a pending read and a pending write, and issues a single-beat request downstream. It keeps issuing before earlier answers have come back, so a stream of transfers moves at one per cycle.

Every acknowledge from the register file goes into a response buffer. The buffer hands the responses back in issue order: writes on B and reads on R, always with OKAY status. A counter tracks the requests that have been issued but not yet answered. It is limited to the register file latency plus two, which covers the full round trip, and the response buffer is exactly that deep. A response therefore always has a slot, even when the AXI master stalls B or R.

Top module: `axil_csr_bridge`

## Requirements
- R1: After reset, `s_awready_o`, `s_wready_o` and `s_arready_o` are 1, and `s_bvalid_o`, `s_rvalid_o` and `req_o` are 0.
- R2: A write request (`req_o`=1, `req_wr_o`=1) is issued only once both its address beat and its data beat have been accepted, in either order. The request carries the data of that W beat.
- R3: The number of requests issued and not yet answered by a B or R handshake never exceeds MAX_OUT = RF_LATENCY + 2 and never goes below zero. With R stalled, exactly MAX_OUT reads are issued.
- R4: Responses leave in request issue order: a write on B, a read on R, never both in the same cycle. Both `s_bresp_o` and `s_rresp_o` are 2'b00 (OKAY).
- R5: `s_rdata_o` of each R beat equals the `rd_data_i` that came with that read's acknowledge, and it holds while R is stalled.
- R6: When a read and a complete write are both pending, the request type other than the last one issued goes first. After reset the read goes first, so continuous streams of both types alternate read, write, read and so on.
- R7: Reads that arrive back to back, or writes that arrive back to back, with B and R ready, are issued on consecutive cycles.
- R8: AXI addresses are byte offsets within the block. `req_addr_o` is the captured address with its low log2(DATA_W/8) bits cleared (bits [1:0] for 32-bit data).
- R9: `req_wstrb_o` carries the byte strobes of the W beat unchanged. Bit b selects byte lane [8b+7:8b].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_awaddr_i | input | ADDR_W | Write byte address |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_wdata_i | input | DATA_W | Write data |
| s_wstrb_i | input | DATA_W/8 | Write byte strobes |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_bresp_o | output | 2 | Write response code |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_araddr_i | input | ADDR_W | Read byte address |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| s_rdata_o | output | DATA_W | Read data |
| s_rresp_o | output | 2 | Read response code |
| req_o | output | 1 | Request strobe to register file |
| req_wr_o | output | 1 | Request is a write |
| req_addr_o | output | ADDR_W | Word-aligned byte address |
| req_wdata_o | output | DATA_W | Write data |
| req_wstrb_o | output | DATA_W/8 | Write byte strobes |
| rd_ack_i | input | 1 | Read acknowledge |
| rd_data_i | input | DATA_W | Read data with acknowledge |
| wr_ack_i | input | 1 | Write acknowledge |

## Verification
The bench builds the bridge with ADDR_W=6, DATA_W=32 and RF_LATENCY=2. This gives a 16-word space that it sweeps in full for writes and for reads, and a MAX_OUT of 4, so the outstanding limit can be reached within a few cycles by stalling R. A register-file model with the same two-cycle latency answers the requests, so the round trip in the bench matches the one MAX_OUT is sized for, and the back-to-back and alternation patterns run at full rate. The small configuration also reaches both arrival orders of the address and data beats, a partial-strobe merge, and the arbitration state right after a mid-run reset.

// File: rtl/axil_csr_pkg.sv
package axil_csr_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  // round trip: issue, RF_LATENCY cycles, buffer push, handshake
  function automatic int max_outstanding(input int rf_latency);
    return rf_latency + 2;
  endfunction
endpackage

// File: rtl/axil_csr_hold.sv
module axil_csr_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  output logic [W-1:0] out_data_o,
  input  logic         pop_i
);
  logic         full_q;
  logic [W-1:0] data_q;

  // refill in the same cycle the entry leaves
  assign in_ready_o  = !full_q || pop_i;
  assign out_valid_o = full_q;
  assign out_data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_valid_i && in_ready_o) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/axil_csr_arb.sv
module axil_csr_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_pend_i,
  input  logic wr_pend_i,
  input  logic slot_ok_i,
  output logic rd_go_o,
  output logic wr_go_o
);
  logic prev_rd_q;

  always_comb begin
    rd_go_o = slot_ok_i && rd_pend_i && (!wr_pend_i || !prev_rd_q);
    wr_go_o = slot_ok_i && wr_pend_i && (!rd_pend_i || prev_rd_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prev_rd_q <= 1'b0;
    else if (rd_go_o) prev_rd_q <= 1'b1;
    else if (wr_go_o) prev_rd_q <= 1'b0;
  end
endmodule

// File: rtl/axil_csr_rsp_fifo.sv
module axil_csr_rsp_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 33
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] dout_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign valid_o = (cnt_q != '0);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)  rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/axil_csr_bridge.sv
module axil_csr_bridge
  import axil_csr_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int RF_LATENCY = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  input  logic [ADDR_W-1:0]   s_awaddr_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic [DATA_W/8-1:0] s_wstrb_i,
  output logic                s_bvalid_o,
  input  logic                s_bready_i,
  output logic [1:0]          s_bresp_o,
  input  logic                s_arvalid_i,
  output logic                s_arready_o,
  input  logic [ADDR_W-1:0]   s_araddr_i,
  output logic                s_rvalid_o,
  input  logic                s_rready_i,
  output logic [DATA_W-1:0]   s_rdata_o,
  output logic [1:0]          s_rresp_o,
  output logic                req_o,
  output logic                req_wr_o,
  output logic [ADDR_W-1:0]   req_addr_o,
  output logic [DATA_W-1:0]   req_wdata_o,
  output logic [DATA_W/8-1:0] req_wstrb_o,
  input  logic                rd_ack_i,
  input  logic [DATA_W-1:0]   rd_data_i,
  input  logic                wr_ack_i
);
  localparam int STRB_W  = DATA_W / 8;
  localparam int MAX_OUT = max_outstanding(RF_LATENCY);
  localparam int CNT_W   = $clog2(MAX_OUT + 1);
  localparam int RSP_W   = DATA_W + 1;

  logic                aw_full, w_full, ar_full;
  logic [ADDR_W-1:0]   aw_addr, ar_addr;
  logic [DATA_W+STRB_W-1:0] w_bundle;
  logic                rd_go, wr_go, slot_ok;
  logic [CNT_W-1:0]    inflight_q;
  logic                rsp_valid, rsp_pop;
  logic [RSP_W-1:0]    rsp_head;

  axil_csr_hold #(.W(ADDR_W)) u_aw (
    .clk_i, .rst_ni,
    .in_valid_i (s_awvalid_i), .in_ready_o (s_awready_o), .in_data_i (s_awaddr_i),
    .out_valid_o(aw_full), .out_data_o(aw_addr), .pop_i(wr_go)
  );

  axil_csr_hold #(.W(DATA_W + STRB_W)) u_w (
    .clk_i, .rst_ni,
    .in_valid_i (s_wvalid_i), .in_ready_o (s_wready_o), .in_data_i ({s_wstrb_i, s_wdata_i}),
    .out_valid_o(w_full), .out_data_o(w_bundle), .pop_i(wr_go)
  );

  axil_csr_hold #(.W(ADDR_W)) u_ar (
    .clk_i, .rst_ni,
    .in_valid_i (s_arvalid_i), .in_ready_o (s_arready_o), .in_data_i (s_araddr_i),
    .out_valid_o(ar_full), .out_data_o(ar_addr), .pop_i(rd_go)
  );

  // counter is bounded by MAX_OUT, so the buffer below can never overflow
  assign slot_ok = (inflight_q < CNT_W'(MAX_OUT));

  axil_csr_arb u_arb (
    .clk_i, .rst_ni,
    .rd_pend_i(ar_full), .wr_pend_i(aw_full && w_full), .slot_ok_i(slot_ok),
    .rd_go_o(rd_go), .wr_go_o(wr_go)
  );

  assign req_o       = rd_go || wr_go;
  assign req_wr_o    = wr_go;
  assign req_addr_o  = (wr_go ? aw_addr : ar_addr) & ~ADDR_W'(STRB_W - 1);
  assign req_wdata_o = w_bundle[DATA_W-1:0];
  assign req_wstrb_o = w_bundle[DATA_W+STRB_W-1:DATA_W];

  axil_csr_rsp_fifo #(.DEPTH(MAX_OUT), .W(RSP_W)) u_rsp (
    .clk_i, .rst_ni,
    .push_i (rd_ack_i || wr_ack_i),
    .din_i  ({wr_ack_i, rd_ack_i ? rd_data_i : '0}),
    .pop_i  (rsp_pop),
    .valid_o(rsp_valid),
    .dout_o (rsp_head)
  );

  assign s_bvalid_o = rsp_valid &&  rsp_head[DATA_W];
  assign s_rvalid_o = rsp_valid && !rsp_head[DATA_W];
  assign s_rdata_o  = rsp_head[DATA_W-1:0];
  assign s_bresp_o  = RESP_OKAY;
  assign s_rresp_o  = RESP_OKAY;
  assign rsp_pop    = (s_bvalid_o && s_bready_i) || (s_rvalid_o && s_rready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inflight_q <= '0;
    else         inflight_q <= inflight_q + CNT_W'(req_o) - CNT_W'(rsp_pop);
  end
endmodule

// File: rtl/axil_csr_bridge_chk.sv
module axil_csr_bridge_chk #(
  parameter int DATA_W     = 32,
  parameter int RF_LATENCY = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              s_bvalid_o,
  input logic              s_bready_i,
  input logic [1:0]        s_bresp_o,
  input logic              s_rvalid_o,
  input logic              s_rready_i,
  input logic [DATA_W-1:0] s_rdata_o,
  input logic [1:0]        s_rresp_o
);
  localparam int MAX_OUT = RF_LATENCY + 2;

  logic [7:0] open_q;
  logic       done;
  assign done = (s_bvalid_o && s_bready_i) || (s_rvalid_o && s_rready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= '0;
    else         open_q <= open_q + 8'(req_o) - 8'(done);
  end

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q <= 8'(MAX_OUT));
  p_issue_has_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> open_q < 8'(MAX_OUT));
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> open_q != '0);
  p_one_channel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_bvalid_o && s_rvalid_o));
  p_okay_b_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> s_bresp_o == 2'b00);
  p_okay_r_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o |-> s_rresp_o == 2'b00);
  p_b_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o);
  p_r_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));
endmodule

bind axil_csr_bridge axil_csr_bridge_chk #(.DATA_W(DATA_W), .RF_LATENCY(RF_LATENCY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o),
  .s_bvalid_o(s_bvalid_o), .s_bready_i(s_bready_i), .s_bresp_o(s_bresp_o),
  .s_rvalid_o(s_rvalid_o), .s_rready_i(s_rready_i), .s_rdata_o(s_rdata_o),
  .s_rresp_o(s_rresp_o)
);

// File: tb/sim_axil_csr_bridge.sv
module sim_axil_csr_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int LAT    = 2;
  localparam int MAXO   = LAT + 2;
  localparam int STRB_W = DATA_W / 8;
  localparam int WORDS  = 16;
  localparam int LOG_N  = 256;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic s_awvalid_i = 0, s_wvalid_i = 0, s_arvalid_i = 0, s_bready_i = 1, s_rready_i = 1;
  logic [ADDR_W-1:0] s_awaddr_i = '0, s_araddr_i = '0;
  logic [DATA_W-1:0] s_wdata_i = '0;
  logic [STRB_W-1:0] s_wstrb_i = '0;
  logic s_awready_o, s_wready_o, s_arready_o, s_bvalid_o, s_rvalid_o;
  logic [1:0] s_bresp_o, s_rresp_o;
  logic [DATA_W-1:0] s_rdata_o;
  logic req_o, req_wr_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [DATA_W-1:0] req_wdata_o;
  logic [STRB_W-1:0] req_wstrb_o;
  logic rd_ack_i, wr_ack_i;
  logic [DATA_W-1:0] rd_data_i;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  axil_csr_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RF_LATENCY(LAT)) u0 (.*);

  // register file model: fixed latency, in order
  logic [DATA_W-1:0] rf_mem [WORDS];
  logic [LAT-1:0] st_v, st_w;
  logic [DATA_W-1:0] st_d [LAT];
  assign rd_ack_i  = st_v[LAT-1] && !st_w[LAT-1];
  assign wr_ack_i  = st_v[LAT-1] &&  st_w[LAT-1];
  assign rd_data_i = st_d[LAT-1];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_v <= '0;
      st_w <= '0;
    end else begin
      for (int k = LAT-1; k > 0; k--) begin
        st_v[k] <= st_v[k-1]; st_w[k] <= st_w[k-1]; st_d[k] <= st_d[k-1];
      end
      st_v[0] <= req_o;
      st_w[0] <= req_wr_o;
      st_d[0] <= rf_mem[req_addr_o[ADDR_W-1:2]];
      if (req_o && req_wr_o)
        for (int b = 0; b < STRB_W; b++)
          if (req_wstrb_o[b]) rf_mem[req_addr_o[ADDR_W-1:2]][8*b +: 8] <= req_wdata_o[8*b +: 8];
    end
  end

  // port monitor
  int cyc = 0, req_n = 0, rsp_n = 0;
  logic              lg_req_wr [LOG_N];
  logic [ADDR_W-1:0] lg_req_addr [LOG_N];
  logic [DATA_W-1:0] lg_req_data [LOG_N];
  logic [STRB_W-1:0] lg_req_strb [LOG_N];
  int                lg_req_cyc [LOG_N];
  logic              lg_rsp_wr [LOG_N];
  logic [DATA_W-1:0] lg_rsp_data [LOG_N];
  logic [1:0]        lg_rsp_code [LOG_N];

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && req_o && req_n < LOG_N) begin
      lg_req_wr[req_n] <= req_wr_o; lg_req_addr[req_n] <= req_addr_o;
      lg_req_data[req_n] <= req_wdata_o; lg_req_strb[req_n] <= req_wstrb_o;
      lg_req_cyc[req_n] <= cyc; req_n <= req_n + 1;
    end
    if (rst_ni && rsp_n < LOG_N) begin
      if (s_bvalid_o && s_bready_i) begin
        lg_rsp_wr[rsp_n] <= 1'b1; lg_rsp_data[rsp_n] <= '0;
        lg_rsp_code[rsp_n] <= s_bresp_o; rsp_n <= rsp_n + 1;
      end else if (s_rvalid_o && s_rready_i) begin
        lg_rsp_wr[rsp_n] <= 1'b0; lg_rsp_data[rsp_n] <= s_rdata_o;
        lg_rsp_code[rsp_n] <= s_rresp_o; rsp_n <= rsp_n + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DATA_W-1:0] exp_mem [WORDS];

  task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] fdata(input int i);
    return {8'(i), 8'(~i), 16'h5A00 + 16'(i * 7)};
  endfunction

  task automatic send_aw(input logic [ADDR_W-1:0] a);
    bit hs;
    s_awvalid_i = 1; s_awaddr_i = a;
    do begin #1; hs = s_awready_o; @(negedge clk_i); end while (!hs);
    s_awvalid_i = 0;
  endtask

  task automatic send_w(input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s);
    bit hs;
    s_wvalid_i = 1; s_wdata_i = d; s_wstrb_i = s;
    do begin #1; hs = s_wready_o; @(negedge clk_i); end while (!hs);
    s_wvalid_i = 0;
  endtask

  task automatic send_ar(input logic [ADDR_W-1:0] a);
    bit hs;
    s_arvalid_i = 1; s_araddr_i = a;
    do begin #1; hs = s_arready_o; @(negedge clk_i); end while (!hs);
    s_arvalid_i = 0;
  endtask

  task automatic wait_rsp(input int target);
    int t = 0;
    while (rsp_n < target && t < 300) begin @(negedge clk_i); t++; end
    chk(rsp_n >= target, "R4 drain", DATA_W'(rsp_n), DATA_W'(target));
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mr, mp;
    bit seq_ok;
    do_reset();

    // R1 reset state
    chk(s_awready_o == 1, "R1 awready", DATA_W'(s_awready_o), 1);
    chk(s_wready_o == 1,  "R1 wready",  DATA_W'(s_wready_o), 1);
    chk(s_arready_o == 1, "R1 arready", DATA_W'(s_arready_o), 1);
    chk(s_bvalid_o == 0,  "R1 bvalid",  DATA_W'(s_bvalid_o), 0);
    chk(s_rvalid_o == 0,  "R1 rvalid",  DATA_W'(s_rvalid_o), 0);
    chk(req_o == 0,       "R1 req",     DATA_W'(req_o), 0);

    // write sweep, low address bits scrambled
    mr = req_n; mp = rsp_n;
    fork
      for (int i = 0; i < WORDS; i++) send_aw(ADDR_W'(4*i + (i % 4)));
      for (int i = 0; i < WORDS; i++) send_w(fdata(i), '1);
    join
    wait_rsp(mp + WORDS);
    seq_ok = 1;
    for (int i = 0; i < WORDS; i++) begin
      exp_mem[i] = fdata(i);
      chk(lg_req_wr[mr+i] == 1, "R2 write type", DATA_W'(lg_req_wr[mr+i]), 1);
      chk(lg_req_addr[mr+i] == ADDR_W'(4*i), "R8 aligned addr", DATA_W'(lg_req_addr[mr+i]), DATA_W'(4*i));
      chk(lg_req_data[mr+i] == fdata(i), "R2 write data", lg_req_data[mr+i], fdata(i));
      chk(lg_rsp_wr[mp+i] == 1 && lg_rsp_code[mp+i] == 2'b00, "R4 B okay", DATA_W'({lg_rsp_wr[mp+i], lg_rsp_code[mp+i]}), 32'h4);
      if (i > 0 && lg_req_cyc[mr+i] != lg_req_cyc[mr+i-1] + 1) seq_ok = 0;
    end
    chk(seq_ok, "R7 write back-to-back", DATA_W'(lg_req_cyc[mr+WORDS-1] - lg_req_cyc[mr]), DATA_W'(WORDS-1));

    // read sweep
    mr = req_n; mp = rsp_n;
    for (int i = 0; i < WORDS; i++) send_ar(ADDR_W'(4*i + 3 - (i % 4)));
    wait_rsp(mp + WORDS);
    seq_ok = 1;
    for (int i = 0; i < WORDS; i++) begin
      chk(lg_req_addr[mr+i] == ADDR_W'(4*i), "R8 read addr", DATA_W'(lg_req_addr[mr+i]), DATA_W'(4*i));
      chk(lg_rsp_wr[mp+i] == 0 && lg_rsp_code[mp+i] == 2'b00, "R4 R okay", DATA_W'({lg_rsp_wr[mp+i], lg_rsp_code[mp+i]}), 0);
      chk(lg_rsp_data[mp+i] == exp_mem[i], "R5 read data", lg_rsp_data[mp+i], exp_mem[i]);
      if (i > 0 && lg_req_cyc[mr+i] != lg_req_cyc[mr+i-1] + 1) seq_ok = 0;
    end
    chk(seq_ok, "R7 read back-to-back", DATA_W'(lg_req_cyc[mr+WORDS-1] - lg_req_cyc[mr]), DATA_W'(WORDS-1));

    // W before AW, partial strobes
    mr = req_n; mp = rsp_n;
    send_w(32'hAABBCCDD, 4'b0101);
    repeat (3) @(negedge clk_i);
    chk(req_n == mr, "R2 no issue on W alone", DATA_W'(req_n - mr), 0);
    send_aw(ADDR_W'(12));
    wait_rsp(mp + 1);
    chk(lg_req_wr[mr] == 1 && lg_req_addr[mr] == 12, "R2 W-first issue", DATA_W'(lg_req_addr[mr]), 12);
    chk(lg_req_strb[mr] == 4'b0101, "R9 strobes", DATA_W'(lg_req_strb[mr]), 4'b0101);
    exp_mem[3] = {exp_mem[3][31:24], 8'hBB, exp_mem[3][15:8], 8'hDD};

    // AW before W
    mr = req_n; mp = rsp_n;
    send_aw(ADDR_W'(20));
    repeat (3) @(negedge clk_i);
    chk(req_n == mr, "R2 no issue on AW alone", DATA_W'(req_n - mr), 0);
    send_w(32'h0BAD_F00D, '1);
    wait_rsp(mp + 1);
    chk(lg_req_data[mr] == 32'h0BAD_F00D && lg_req_addr[mr] == 20, "R2 AW-first issue", lg_req_data[mr], 32'h0BAD_F00D);
    exp_mem[5] = 32'h0BAD_F00D;

    // outstanding limit with R stalled
    s_rready_i = 0;
    mr = req_n; mp = rsp_n;
    fork
      for (int i = 0; i < 6; i++) send_ar(ADDR_W'(4*i));
    join_none
    repeat (20) @(negedge clk_i);
    chk(req_n - mr == MAXO, "R3 issue cap", DATA_W'(req_n - mr), DATA_W'(MAXO));
    chk(s_rvalid_o == 1, "R5 R held while stalled", DATA_W'(s_rvalid_o), 1);
    chk(s_rdata_o == exp_mem[0], "R5 stalled data", s_rdata_o, exp_mem[0]);
    s_rready_i = 1;
    wait_rsp(mp + 6);
    for (int i = 0; i < 6; i++)
      chk(lg_rsp_wr[mp+i] == 0 && lg_rsp_data[mp+i] == exp_mem[i], "R4 in-order reads", lg_rsp_data[mp+i], exp_mem[i]);
    repeat (4) @(negedge clk_i);

    // arbitration after reset: read first, then alternate
    do_reset();
    mr = req_n; mp = rsp_n;
    fork
      for (int i = 0; i < 4; i++) send_ar(ADDR_W'(4*(8+i)));
      for (int i = 0; i < 4; i++) send_aw(ADDR_W'(4*(12+i)));
      for (int i = 0; i < 4; i++) send_w(fdata(100+i), '1);
    join
    wait_rsp(mp + 8);
    for (int k = 0; k < 8; k++) begin
      chk(lg_req_wr[mr+k] == (k % 2), "R6 alternation", DATA_W'(lg_req_wr[mr+k]), DATA_W'(k % 2));
      chk(lg_rsp_wr[mp+k] == (k % 2), "R4 response order", DATA_W'(lg_rsp_wr[mp+k]), DATA_W'(k % 2));
    end
    for (int i = 0; i < 4; i++) begin
      chk(lg_rsp_data[mp+2*i] == exp_mem[8+i], "R5 mixed read data", lg_rsp_data[mp+2*i], exp_mem[8+i]);
      exp_mem[12+i] = fdata(100+i);
    end

    // readback of the written words
    mp = rsp_n;
    for (int i = 12; i < 16; i++) send_ar(ADDR_W'(4*i));
    wait_rsp(mp + 4);
    for (int i = 0; i < 4; i++)
      chk(lg_rsp_data[mp+i] == exp_mem[12+i], "R5 readback", lg_rsp_data[mp+i], exp_mem[12+i]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule